// File: doc/BRIEF.md
# Diff-Based Redundancy Update Engine

This engine sits between a last-level cache and a protected memory region. It takes each dirty-line write-back, fetches the line's current contents and stored checksums, and XORs the old and new lines to get a difference vector. From that difference alone it derives three new metadata values: the per-line checksum, the per-page checksum and the page parity. It never reads the other lines of the page.

CRC linearity makes this possible. The new line checksum is the old one XOR the CRC of the difference XOR the CRC of an all-zero line. The page checksum uses the same rule. The difference sits at the line's slot within the page with zeros elsewhere, so its zero-initialised CRC is carried forward across the trailing zero lines.

The data write and the metadata writes form one group, and the group is protected by a lock. The lock stays up from the moment the old contents are requested until the last write of the group is acknowledged. Readers consult a probe port that reports whether a given line address is locked. Only one group is in flight at a time, so write-backs to the same line are handled strictly one after another.

Top module: `rue_engine`

## Requirements
- R1: After reset the engine is idle: `wb_ready` is 1, `lock_active` and `probe_busy` are 0, and neither `rd_req_valid` nor `wr_valid` is asserted.
- R2: Each accepted write-back causes exactly one old-contents read, and that read targets the write-back's address. `lock_active` is already high whenever `rd_req_valid` is high.
- R3: The data write (kind 0) carries the new line. The parity write (kind 3) carries old XOR new, and storage XORs that value into the page parity. After the group, the parity equals the XOR of all lines of the page.
- R4: The line-checksum write (kind 1) carries, in its low 32 bits, the CRC of the new line. The CRC uses polynomial 0x1EDC6F41, most significant bit first, initial value all ones and final inversion. It is formed as old checksum XOR CRC(diff) XOR CRC(zero line).
- R5: The page-checksum write (kind 2) carries, in its low 32 bits, the CRC (as in R4) of the whole page. The page is fed as line 0 first through the last line; the line index is the low log2(PAGE_LINES) address bits, and the page is the remaining bits. No other line of the page is read to form it.
- R6: A write-back with a non-zero diff issues exactly four writes, in the order kind 0, 1, 2, 3.
- R7: If the diff is all zero, only the data write (kind 0) is issued and all three metadata writes are skipped.
- R8: `lock_active` stays high until every issued write has been acknowledged on `wr_ack`. No write is issued while it is low.
- R9: `wb_ready` is low while a group is in flight. A second write-back to the same line is accepted only after the first group commits, and the second one's data is what remains.
- R10: `probe_busy` is 1 only when `probe_addr` equals the address of the group in flight.
- R11: A write stalled by a low `wr_ready` keeps its kind, address and data stable until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_valid | input | 1 | Write-back offered |
| wb_ready | output | 1 | Engine can accept a write-back |
| wb_addr | input | ADDR_W | Line address of the write-back |
| wb_data | input | LINE_W | New (dirty) line contents |
| rd_req_valid | output | 1 | Old-contents read request |
| rd_req_ready | input | 1 | Storage accepts the read request |
| rd_req_addr | output | ADDR_W | Line address to read |
| rd_rsp_valid | input | 1 | Read response present |
| rd_rsp_data | input | LINE_W | Old line contents |
| rd_rsp_line_ck | input | 32 | Stored line checksum |
| rd_rsp_page_ck | input | 32 | Stored checksum of the line's page |
| wr_valid | output | 1 | Write request |
| wr_ready | input | 1 | Storage accepts the write |
| wr_kind | output | 2 | 0 data, 1 line checksum, 2 page checksum, 3 parity XOR |
| wr_addr | output | ADDR_W | Line address of the group |
| wr_data | output | LINE_W | Write payload (checksums in the low 32 bits) |
| wr_ack | input | 1 | One pulse per completed write |
| probe_addr | input | ADDR_W | Line address a reader wants to check |
| probe_busy | output | 1 | Probed line is locked |
| lock_active | output | 1 | A group is in flight |

## Verification
Two things can land in the same cycle: the last acknowledgement of a group, and a reader or a new write-back to the same line waiting on the lock. The bench sets this up in two ways. It withholds acknowledgements while probing the locked address and a neighbour. It also offers a second write-back to a line whose group is still open, then releases the acknowledgements so that the lock drop and the next acceptance come close together. The result is judged from the storage model's final data, checksums and parity, recomputed from the whole page image. It is also judged from the write counts and write order logged in the model.

// File: rtl/rue_pkg.sv
package rue_pkg;
   localparam int CK_W     = 32;
   localparam int CRC_MAXW = 1024;

   typedef logic [CK_W-1:0] ck_t;

   typedef enum logic [1:0] {
      WK_DATA    = 2'd0,
      WK_LINE_CK = 2'd1,
      WK_PAGE_CK = 2'd2,
      WK_PARITY  = 2'd3
   } wr_kind_e;

   // Shift n bits of d (bit n-1 first) through a CRC register.
   function automatic ck_t crc_feed(ck_t st, logic [CRC_MAXW-1:0] d,
                                    int unsigned n, ck_t poly);
      ck_t  s;
      logic fb;
      s = st;
      for (int i = CRC_MAXW-1; i >= 0; i--) begin
         if (i < int'(n)) begin
            fb = s[CK_W-1] ^ d[i];
            s  = {s[CK_W-2:0], 1'b0};
            if (fb) s = s ^ poly;
         end
      end
      return s;
   endfunction
endpackage

// File: rtl/rue_diff_crc.sv
module rue_diff_crc
   import rue_pkg::*;
#(
   parameter int  LINE_W = 64,
   parameter ck_t POLY   = 32'h1EDC6F41
) (
   input  logic [LINE_W-1:0] new_line,
   input  logic [LINE_W-1:0] old_line,
   output logic [LINE_W-1:0] diff,
   output logic              diff_zero,
   output ck_t               line_delta,
   output ck_t               page_seed
);
   localparam ck_t ONES    = '1;
   localparam ck_t ZERO_CK = ~crc_feed(ONES, '0, LINE_W, POLY);

   ck_t full_ck;

   always_comb begin
      diff       = new_line ^ old_line;
      diff_zero  = (diff == '0);
      full_ck    = ~crc_feed(ONES, CRC_MAXW'(diff), LINE_W, POLY);
      line_delta = full_ck ^ ZERO_CK;
      page_seed  = crc_feed('0, CRC_MAXW'(diff), LINE_W, POLY);
   end
endmodule

// File: rtl/rue_page_adv.sv
module rue_page_adv
   import rue_pkg::*;
#(
   parameter int  LINE_W     = 64,
   parameter int  PAGE_LINES = 8,
   parameter ck_t POLY       = 32'h1EDC6F41,
   parameter bit  SERIAL     = 1'b1,
   localparam int IDX_W      = $clog2(PAGE_LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  ck_t              seed,
   input  logic [IDX_W-1:0] zero_lines,
   output logic             done,
   output ck_t              result
);
   if (SERIAL) begin : g_serial
      logic             run;
      logic [IDX_W-1:0] cnt;
      ck_t              acc;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
            acc <= '0;
         end else if (start) begin
            run <= 1'b1;
            cnt <= zero_lines;
            acc <= seed;
         end else if (run) begin
            if (cnt != '0) begin
               acc <= crc_feed(acc, '0, LINE_W, POLY);
               cnt <= cnt - 1'b1;
            end else begin
               run <= 1'b0;
            end
         end
      end

      assign done   = run && (cnt == '0);
      assign result = acc;
   end else begin : g_parallel
      ck_t              seed_q;
      logic [IDX_W-1:0] zl_q;
      logic             done_q;
      ck_t              chain [PAGE_LINES];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            seed_q <= '0;
            zl_q   <= '0;
            done_q <= 1'b0;
         end else begin
            done_q <= start;
            if (start) begin
               seed_q <= seed;
               zl_q   <= zero_lines;
            end
         end
      end

      assign chain[0] = seed_q;
      for (genvar k = 1; k < PAGE_LINES; k++) begin : g_stage
         assign chain[k] = crc_feed(chain[k-1], '0, LINE_W, POLY);
      end

      assign done   = done_q;
      assign result = chain[zl_q];
   end
endmodule

// File: rtl/rue_commit.sv
module rue_commit
   import rue_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int LINE_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              diff_zero,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LINE_W-1:0] new_line,
   input  logic [LINE_W-1:0] diff,
   input  ck_t               line_ck,
   input  ck_t               page_ck,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [1:0]        wr_kind,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [LINE_W-1:0] wr_data,
   input  logic              wr_ack,
   output logic              done
);
   logic       active;
   logic [2:0] issued;
   logic [2:0] acked;
   logic [1:0] step;
   logic [2:0] need;
   logic       hs;

   assign need     = diff_zero ? 3'd1 : 3'd4;
   assign wr_valid = active && (issued != need);
   assign hs       = wr_valid && wr_ready;
   assign done     = active && (issued == need) && (acked == need);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         issued <= '0;
         acked  <= '0;
         step   <= '0;
      end else if (start) begin
         active <= 1'b1;
         issued <= '0;
         acked  <= '0;
         step   <= '0;
      end else if (active) begin
         if (done) active <= 1'b0;
         if (hs) begin
            issued <= issued + 3'd1;
            step   <= step + 2'd1;
         end
         if (wr_ack) acked <= acked + 3'd1;
      end
   end

   always_comb begin
      wr_kind = step;
      wr_addr = addr;
      unique case (wr_kind_e'(step))
         WK_DATA:    wr_data = new_line;
         WK_LINE_CK: wr_data = LINE_W'(line_ck);
         WK_PAGE_CK: wr_data = LINE_W'(page_ck);
         default:    wr_data = diff;
      endcase
   end
endmodule

// File: rtl/rue_engine.sv
module rue_engine
   import rue_pkg::*;
#(
   parameter int  ADDR_W         = 10,
   parameter int  LINE_W         = 64,
   parameter int  PAGE_LINES     = 8,
   parameter ck_t POLY           = 32'h1EDC6F41,
   parameter bit  SERIAL_ADVANCE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wb_valid,
   output logic              wb_ready,
   input  logic [ADDR_W-1:0] wb_addr,
   input  logic [LINE_W-1:0] wb_data,
   output logic              rd_req_valid,
   input  logic              rd_req_ready,
   output logic [ADDR_W-1:0] rd_req_addr,
   input  logic              rd_rsp_valid,
   input  logic [LINE_W-1:0] rd_rsp_data,
   input  logic [31:0]       rd_rsp_line_ck,
   input  logic [31:0]       rd_rsp_page_ck,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [1:0]        wr_kind,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [LINE_W-1:0] wr_data,
   input  logic              wr_ack,
   input  logic [ADDR_W-1:0] probe_addr,
   output logic              probe_busy,
   output logic              lock_active
);
   localparam int IDX_W = $clog2(PAGE_LINES);

   if (LINE_W % 8 != 0 || LINE_W > CRC_MAXW || LINE_W < CK_W) begin : g_bad_line
      $error("rue_engine: LINE_W must be a byte multiple between 32 and CRC_MAXW");
   end
   if (PAGE_LINES < 2 || (1 << IDX_W) != PAGE_LINES) begin : g_bad_page
      $error("rue_engine: PAGE_LINES must be a power of two of at least 2");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("rue_engine: ADDR_W must exceed the line-index width");
   end

   typedef enum logic [2:0] {
      S_IDLE, S_RDREQ, S_RDWAIT, S_CALC, S_ADV, S_COMMIT
   } state_e;

   state_e            state;
   logic [ADDR_W-1:0] addr_q;
   logic [LINE_W-1:0] new_q;
   logic [LINE_W-1:0] old_q;
   ck_t               old_line_ck_q;
   ck_t               old_page_ck_q;
   logic [LINE_W-1:0] diff_q;
   logic              diff_zero_q;
   ck_t               line_ck_q;
   ck_t               page_ck_q;

   logic [LINE_W-1:0] diff_c;
   logic              diff_zero_c;
   ck_t               line_delta_c;
   ck_t               page_seed_c;
   logic              adv_start;
   logic              adv_done;
   ck_t               adv_result;
   logic [IDX_W-1:0]  zero_lines;
   logic              commit_start;
   logic              commit_done;

   rue_diff_crc #(.LINE_W(LINE_W), .POLY(POLY)) u_diff (
      .new_line   (new_q),
      .old_line   (old_q),
      .diff       (diff_c),
      .diff_zero  (diff_zero_c),
      .line_delta (line_delta_c),
      .page_seed  (page_seed_c)
   );

   assign zero_lines = IDX_W'(PAGE_LINES - 1) - addr_q[IDX_W-1:0];

   rue_page_adv #(
      .LINE_W(LINE_W), .PAGE_LINES(PAGE_LINES), .POLY(POLY), .SERIAL(SERIAL_ADVANCE)
   ) u_adv (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (adv_start),
      .seed       (page_seed_c),
      .zero_lines (zero_lines),
      .done       (adv_done),
      .result     (adv_result)
   );

   rue_commit #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_commit (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (commit_start),
      .diff_zero (diff_zero_q),
      .addr      (addr_q),
      .new_line  (new_q),
      .diff      (diff_q),
      .line_ck   (line_ck_q),
      .page_ck   (page_ck_q),
      .wr_valid  (wr_valid),
      .wr_ready  (wr_ready),
      .wr_kind   (wr_kind),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .wr_ack    (wr_ack),
      .done      (commit_done)
   );

   assign wb_ready     = (state == S_IDLE);
   assign rd_req_valid = (state == S_RDREQ);
   assign rd_req_addr  = addr_q;
   assign adv_start    = (state == S_CALC);
   assign commit_start = (state == S_ADV) && adv_done;
   assign lock_active  = (state != S_IDLE);
   assign probe_busy   = lock_active && (probe_addr == addr_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state         <= S_IDLE;
         addr_q        <= '0;
         new_q         <= '0;
         old_q         <= '0;
         old_line_ck_q <= '0;
         old_page_ck_q <= '0;
         diff_q        <= '0;
         diff_zero_q   <= 1'b0;
         line_ck_q     <= '0;
         page_ck_q     <= '0;
      end else begin
         unique case (state)
            S_IDLE: if (wb_valid) begin
               addr_q <= wb_addr;
               new_q  <= wb_data;
               state  <= S_RDREQ;
            end
            S_RDREQ: if (rd_req_ready) state <= S_RDWAIT;
            S_RDWAIT: if (rd_rsp_valid) begin
               old_q         <= rd_rsp_data;
               old_line_ck_q <= rd_rsp_line_ck;
               old_page_ck_q <= rd_rsp_page_ck;
               state         <= S_CALC;
            end
            S_CALC: begin
               diff_q      <= diff_c;
               diff_zero_q <= diff_zero_c;
               line_ck_q   <= old_line_ck_q ^ line_delta_c;
               state       <= S_ADV;
            end
            S_ADV: if (adv_done) begin
               page_ck_q <= old_page_ck_q ^ adv_result;
               state     <= S_COMMIT;
            end
            S_COMMIT: if (commit_done) state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rue_engine_chk.sv
module rue_engine_chk #(
   parameter int ADDR_W = 10,
   parameter int LINE_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wb_ready,
   input logic              rd_req_valid,
   input logic              wr_valid,
   input logic              wr_ready,
   input logic [1:0]        wr_kind,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [LINE_W-1:0] wr_data,
   input logic              probe_busy,
   input logic              lock_active,
   input logic              diff_zero
);
   AST_RD_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_valid |-> lock_active); // R2

   AST_WR_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> lock_active); // R8

   AST_NO_ACCEPT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      lock_active |-> !wb_ready); // R9

   AST_ZERO_DIFF_DATA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && diff_zero) |-> (wr_kind == 2'd0)); // R7

   AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_kind) && $stable(wr_addr)
                                  && $stable(wr_data))); // R11

   AST_PROBE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      probe_busy |-> lock_active); // R10
endmodule

bind rue_engine rue_engine_chk #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wb_ready     (wb_ready),
   .rd_req_valid (rd_req_valid),
   .wr_valid     (wr_valid),
   .wr_ready     (wr_ready),
   .wr_kind      (wr_kind),
   .wr_addr      (wr_addr),
   .wr_data      (wr_data),
   .probe_busy   (probe_busy),
   .lock_active  (lock_active),
   .diff_zero    (diff_zero_q)
);

// File: tb/rue_engine_tb.sv
module rue_engine_tb;
   localparam int AW = 6;
   localparam int LW = 64;
   localparam int PL = 8;
   localparam int NL = 1 << AW;
   localparam int NP = NL / PL;
   localparam logic [31:0] POLY = 32'h1EDC6F41;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wb_valid = 1'b0;
   logic          wb_ready;
   logic [AW-1:0] wb_addr = '0;
   logic [LW-1:0] wb_data = '0;
   logic          rd_req_valid;
   logic          rd_req_ready = 1'b1;
   logic [AW-1:0] rd_req_addr;
   logic          rd_rsp_valid = 1'b0;
   logic [LW-1:0] rd_rsp_data = '0;
   logic [31:0]   rd_rsp_line_ck = '0;
   logic [31:0]   rd_rsp_page_ck = '0;
   logic          wr_valid;
   logic          wr_ready = 1'b1;
   logic [1:0]    wr_kind;
   logic [AW-1:0] wr_addr;
   logic [LW-1:0] wr_data;
   logic          wr_ack = 1'b0;
   logic [AW-1:0] probe_addr = '0;
   logic          probe_busy;
   logic          lock_active;

   rue_engine #(.ADDR_W(AW), .LINE_W(LW), .PAGE_LINES(PL)) u_dut (.*);

   always #4 clk = ~clk;

   logic [LW-1:0] mem    [NL];
   logic [31:0]   linck  [NL];
   logic [31:0]   pageck [NP];
   logic [LW-1:0] parity [NP];
   int            kcnt   [4];
   int            rdn = 0;
   logic [AW-1:0] rd_last = '0;
   logic [7:0]    klog = '0;
   int            pend = 0;
   bit            ack_en = 1'b1;
   bit            throttle = 1'b0;
   int            vectors = 0;
   int            fails = 0;

   function automatic logic [31:0] m_feed(logic [31:0] s0, logic [LW-1:0] d);
      logic [31:0] s = s0;
      for (int i = LW-1; i >= 0; i--) begin
         logic fb = s[31] ^ d[i];
         s = {s[30:0], 1'b0};
         if (fb) s = s ^ POLY;
      end
      return s;
   endfunction

   function automatic logic [31:0] m_line_ck(logic [LW-1:0] d);
      return ~m_feed(32'hFFFF_FFFF, d);
   endfunction

   function automatic logic [31:0] m_page_ck(int p);
      logic [31:0] s = 32'hFFFF_FFFF;
      for (int l = 0; l < PL; l++) s = m_feed(s, mem[p*PL + l]);
      return ~s;
   endfunction

   function automatic logic [LW-1:0] m_parity(int p);
      logic [LW-1:0] x = '0;
      for (int l = 0; l < PL; l++) x = x ^ mem[p*PL + l];
      return x;
   endfunction

   // storage model
   always @(posedge clk) begin
      bit acc;
      bit ackn;
      if (!rst_n) begin
         rd_rsp_valid <= 1'b0;
         wr_ack       <= 1'b0;
         pend         <= 0;
         wr_ready     <= 1'b1;
      end else begin
         rd_rsp_valid <= rd_req_valid && rd_req_ready;
         if (rd_req_valid && rd_req_ready) begin
            rd_rsp_data    <= mem[rd_req_addr];
            rd_rsp_line_ck <= linck[rd_req_addr];
            rd_rsp_page_ck <= pageck[rd_req_addr / PL];
            rdn            <= rdn + 1;
            rd_last        <= rd_req_addr;
         end
         acc  = wr_valid && wr_ready;
         ackn = ack_en && (pend > 0);
         if (acc) begin
            case (wr_kind)
               2'd0: mem[wr_addr] <= wr_data;
               2'd1: linck[wr_addr] <= wr_data[31:0];
               2'd2: pageck[wr_addr / PL] <= wr_data[31:0];
               default: parity[wr_addr / PL] <= parity[wr_addr / PL] ^ wr_data;
            endcase
            kcnt[wr_kind] <= kcnt[wr_kind] + 1;
            klog <= {klog[5:0], wr_kind};
         end
         wr_ack <= ackn;
         pend <= pend + int'(acc) - int'(ackn);
         wr_ready <= throttle ? ~wr_ready : 1'b1;
      end
   end

   task automatic check(string req, logic [LW-1:0] act, logic [LW-1:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic send_wb(logic [AW-1:0] a, logic [LW-1:0] d);
      @(negedge clk);
      while (!wb_ready) @(negedge clk);
      wb_valid = 1'b1;
      wb_addr  = a;
      wb_data  = d;
      @(negedge clk);
      wb_valid = 1'b0;
   endtask

   task automatic wait_idle();
      while (lock_active) @(negedge clk);
   endtask

   task automatic verify(logic [AW-1:0] a, logic [LW-1:0] d);
      int p = a / PL;
      check("R3 data", mem[a], d);
      check("R3 parity", parity[p], m_parity(p));
      check("R4 line ck", LW'(linck[a]), LW'(m_line_ck(d)));
      check("R5 page ck", LW'(pageck[p]), LW'(m_page_ck(p)));
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1 wb_ready", LW'(wb_ready), 1);
      check("R1 lock", LW'(lock_active), 0);
      check("R1 busy", LW'(probe_busy), 0);
      check("R1 rd_req", LW'(rd_req_valid), 0);
      check("R1 wr_valid", LW'(wr_valid), 0);
   endtask

   task automatic t_basic(logic [AW-1:0] a, logic [LW-1:0] d);
      int k0[4];
      int r0 = rdn;
      for (int i = 0; i < 4; i++) k0[i] = kcnt[i];
      send_wb(a, d);
      wait_idle();
      check("R2 reads", LW'(rdn - r0), 1);
      check("R2 read addr", LW'(rd_last), LW'(a));
      for (int i = 0; i < 4; i++) check("R6 count", LW'(kcnt[i] - k0[i]), 1);
      check("R6 order", LW'(klog), LW'(8'h1B));
      verify(a, d);
   endtask

   task automatic t_zero_diff(logic [AW-1:0] a);
      int k0[4];
      for (int i = 0; i < 4; i++) k0[i] = kcnt[i];
      send_wb(a, mem[a]);
      wait_idle();
      check("R7 data write", LW'(kcnt[0] - k0[0]), 1);
      for (int i = 1; i < 4; i++) check("R7 skipped", LW'(kcnt[i] - k0[i]), 0);
      verify(a, mem[a]);
   endtask

   task automatic t_held_ack();
      logic [LW-1:0] d = 64'hDEAD_BEEF_0BAD_F00D;
      ack_en = 1'b0;
      send_wb(6'd9, d);
      repeat (20) @(negedge clk);
      probe_addr = 6'd9;
      #1;
      check("R10 busy match", LW'(probe_busy), 1);
      probe_addr = 6'd10;
      #1;
      check("R10 busy other", LW'(probe_busy), 0);
      check("R8 lock held", LW'(lock_active), 1);
      check("R9 not ready", LW'(wb_ready), 0);
      ack_en = 1'b1;
      @(negedge clk);
      wait_idle();
      probe_addr = 6'd9;
      #1;
      check("R8 released", LW'(probe_busy), 0);
      verify(6'd9, d);
   endtask

   task automatic t_same_line();
      int k0 = kcnt[0];
      throttle = 1'b1;
      ack_en = 1'b0;
      send_wb(6'd20, 64'h1111_2222_3333_4444);
      @(negedge clk);
      check("R9 held off", LW'(wb_ready), 0);
      fork
         begin repeat (12) @(negedge clk); ack_en = 1'b1; end
         send_wb(6'd20, 64'h5555_6666_7777_8888);
      join
      @(negedge clk);
      wait_idle();
      throttle = 1'b0;
      check("R9 two data writes", LW'(kcnt[0] - k0), 2);
      verify(6'd20, 64'h5555_6666_7777_8888);
   endtask

   initial begin
      for (int i = 0; i < NL; i++) begin
         mem[i]   = {32'(i) * 32'h9E37_79B9, 32'hA5A5_0000 + 32'(i)};
         linck[i] = m_line_ck(mem[i]);
      end
      for (int p = 0; p < NP; p++) begin
         pageck[p] = m_page_ck(p);
         parity[p] = m_parity(p);
      end
      for (int i = 0; i < 4; i++) kcnt[i] = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic(6'd0, 64'h0123_4567_89AB_CDEF);
      t_basic(6'd7, 64'hFFFF_0000_FFFF_0000);
      t_basic(6'd44, 64'h8000_0000_0000_0001);
      t_zero_diff(6'd44);
      t_held_ack();
      t_same_line();
      throttle = 1'b1;
      t_basic(6'd63, 64'h0F0F_0F0F_F0F0_F0F0);
      throttle = 1'b0;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule